// File: doc/BRIEF.md
# Flash Operation Status Flag Generator

This block builds the byte that a parallel NOR flash returns on its read bus while an internal program or erase runs. An embedded-algorithm engine supplies a busy level, a flag that says whether the operation is an erase or a byte program, and bit 7 of the byte being programmed. The host's chip-enable and output-enable strobes are brought into the system clock domain, and each new read access is found as an edge.

While the operation runs, the block replaces array data with a status byte. Bit 7 is a polling bit that depends on the operation and on the written data. Bit 6 is a toggle bit that inverts on every new read access. Bits 5 to 0 read 0.

When busy falls, a short settle window follows. In that window bit 7 already carries array data while the lower bits still hold stale status. After the window, reads return plain array data. A hardware reset input drops all status reporting at once.

Top module: `flash_status_flags`

## Requirements
- R1: After the synchronous reset `rst`, `rd_drive` is 0 and `rd_data` equals `array_data`. The toggle state is cleared, so the first status read after reset shows bit 6 = 1.
- R2: While a byte program runs (`op_busy`=1, `op_erase`=0), `rd_data[7]` is the complement of the captured `wr_poll_bit` and `rd_data[5:0]` is 0.
- R3: While an erase runs (`op_busy`=1, `op_erase`=1), `rd_data[7]` is 0 whatever `wr_poll_bit` holds.
- R4: While an operation runs, `rd_data[6]` inverts once for each new read access, and a read access starts when the synchronised `ce_n` and `oe_n` are both low after not both being low. The toggle state holds 0 when idle, so the first read access of an operation shows 1, the next 0, then 1 again.
- R5: While an operation runs and no new read access starts, `rd_data[6]` holds its value.
- R6: The settle window lasts `TAIL_CYC` cycles (default 8) and begins in the cycle `op_busy` falls. During it, `rd_data[7]` equals `array_data[7]`, `rd_data[6]` holds the last toggle value and `rd_data[5:0]` is 0.
- R7: After the settle window, `rd_data` equals `array_data` and the toggle state is cleared, so the next operation's first read again shows bit 6 = 1.
- R8: While `hw_rst` is 1, `rd_drive` is 0 and `rd_data` equals `array_data` in the same cycle. Once `hw_rst` has been seen during an operation, status stays suppressed until `op_busy` falls, and no settle window follows.
- R9: `rd_drive` is 1 only while both synchronised strobes are low. After both pins go low, it rises on the second rising clock edge. It stays 0 when only one strobe is low.
- R10: `op_erase` and `wr_poll_bit` are captured while `op_busy` is 0 and held while it is 1, so changing them during an operation does not alter bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_rst | input | 1 | Hardware reset request that stops status reporting at once |
| ce_n | input | 1 | Chip enable from the bus, active low, asynchronous |
| oe_n | input | 1 | Output enable from the bus, active low, asynchronous |
| op_busy | input | 1 | High while the embedded program or erase runs |
| op_erase | input | 1 | 1 = erase, 0 = byte program |
| wr_poll_bit | input | 1 | Bit 7 of the byte being programmed |
| array_data | input | 8 | Byte read from the memory array |
| rd_data | output | 8 | Byte presented to the read bus |
| rd_drive | output | 1 | Read bus output enable |

## Verification
The bench covers several corner cases, and each one catches a specific fault:
- **Toggle restart.** It checks that the toggle sequence restarts at 1 for each operation. A design that does not clear the toggle state between operations would start the second operation at 0.
- **Toggle hold.** It checks that bit 6 stays put while the bus is quiet. A design that toggles on a level instead of an edge would drift during a long read.
- **Changed write data.** It changes the written bit while an operation is in flight. A design that does not hold the captured value would flip bit 7 partway through the operation.
- **Settle window.** It samples the last cycle of the window and the first cycle after it. A counter that is off by one would show whole array data too early, or stale bits too late.
- **Hardware reset.** It asserts `hw_rst` in the middle of a read and checks the same cycle, then releases it while busy is still high. A design that only clears state would briefly drive, or would resume status reporting after the release.

// File: rtl/flash_status_pkg.sv
package flash_status_pkg;

    localparam int DQ_W       = 8;
    localparam int POLL_BIT   = DQ_W - 1;
    localparam int TOGGLE_BIT = DQ_W - 2;

    typedef enum logic [1:0] {
        MODE_ARRAY  = 2'd0,
        MODE_STATUS = 2'd1,
        MODE_SETTLE = 2'd2
    } out_mode_e;

    typedef enum logic {
        OP_PROGRAM = 1'b0,
        OP_ERASE   = 1'b1
    } op_kind_e;

    typedef struct packed {
        op_kind_e kind;
        logic     poll;
    } op_ctx_t;

    // Status byte shown while an embedded operation runs.
    function automatic logic [DQ_W-1:0] busy_byte(op_ctx_t ctx, logic tog);
        logic [DQ_W-1:0] b;
        b             = '0;
        b[POLL_BIT]   = (ctx.kind == OP_ERASE) ? 1'b0 : ~ctx.poll;
        b[TOGGLE_BIT] = tog;
        return b;
    endfunction

    // Byte shown just after completion: true bit 7, stale lower bits.
    function automatic logic [DQ_W-1:0] settle_byte(logic [DQ_W-1:0] arr, logic tog);
        logic [DQ_W-1:0] b;
        b             = '0;
        b[POLL_BIT]   = arr[POLL_BIT];
        b[TOGGLE_BIT] = tog;
        return b;
    endfunction

endpackage

// File: rtl/flash_bus_sync.sv
module flash_bus_sync #(
    parameter int          STAGES  = 2,
    parameter int          W       = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stage_q[0] <= RST_VAL;
        else     stage_q[0] <= din;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stage_q[i] <= RST_VAL;
            else     stage_q[i] <= stage_q[i-1];
        end
    end

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/flash_op_tracker.sv
module flash_op_tracker
    import flash_status_pkg::*;
#(
    parameter int TAIL_CYC = 8
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      hw_rst,
    input  logic      op_busy,
    input  logic      op_erase,
    input  logic      wr_poll_bit,
    output out_mode_e mode,
    output op_ctx_t   ctx
);

    localparam int CW = $clog2(TAIL_CYC + 1);

    logic          busy_q;
    logic          abort_q;
    logic [CW-1:0] tail_cnt;
    logic          busy_fall;

    assign busy_fall = busy_q && !op_busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            abort_q <= 1'b0;
            ctx     <= '{kind: OP_PROGRAM, poll: 1'b0};
        end else begin
            busy_q <= op_busy;
            if (hw_rst)        abort_q <= 1'b1;
            else if (!op_busy) abort_q <= 1'b0;
            if (!op_busy) begin
                ctx.kind <= op_kind_e'(op_erase);
                ctx.poll <= wr_poll_bit;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || hw_rst)               tail_cnt <= '0;
        else if (busy_fall && !abort_q)  tail_cnt <= CW'(TAIL_CYC - 1);
        else if (tail_cnt != '0)         tail_cnt <= tail_cnt - 1'b1;
    end

    always_comb begin
        if (hw_rst || abort_q)                mode = MODE_ARRAY;
        else if (op_busy)                     mode = MODE_STATUS;
        else if (busy_q || tail_cnt != '0)    mode = MODE_SETTLE;
        else                                  mode = MODE_ARRAY;
    end

    AST_TAIL_BOUND: assert property (@(posedge clk) disable iff (rst)
        int'(tail_cnt) <= TAIL_CYC - 1);                                  // R6
    AST_ABORT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (hw_rst && op_busy) |=> (mode == MODE_ARRAY));                     // R8

endmodule

// File: rtl/flash_toggle_bit.sv
module flash_toggle_bit (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic flip,
    output logic tog
);

    always_ff @(posedge clk) begin
        if (rst || clear) tog <= 1'b0;
        else if (flip)    tog <= ~tog;
    end

endmodule

// File: rtl/flash_status_flags.sv
module flash_status_flags
    import flash_status_pkg::*;
#(
    parameter int TAIL_CYC    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            hw_rst,
    input  logic            ce_n,
    input  logic            oe_n,
    input  logic            op_busy,
    input  logic            op_erase,
    input  logic            wr_poll_bit,
    input  logic [DQ_W-1:0] array_data,
    output logic [DQ_W-1:0] rd_data,
    output logic            rd_drive
);

    logic [1:0] strobe_s;
    logic       rd_now, rd_prev, rd_edge;
    out_mode_e  mode;
    op_ctx_t    ctx;
    logic       tog;

    flash_bus_sync #(.STAGES(SYNC_STAGES), .W(2), .RST_VAL(2'b11)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({ce_n, oe_n}),
        .dout (strobe_s)
    );

    assign rd_now  = (strobe_s == 2'b00);
    assign rd_edge = rd_now && !rd_prev;

    always_ff @(posedge clk) begin
        if (rst) rd_prev <= 1'b0;
        else     rd_prev <= rd_now;
    end

    flash_op_tracker #(.TAIL_CYC(TAIL_CYC)) u_track (
        .clk         (clk),
        .rst         (rst),
        .hw_rst      (hw_rst),
        .op_busy     (op_busy),
        .op_erase    (op_erase),
        .wr_poll_bit (wr_poll_bit),
        .mode        (mode),
        .ctx         (ctx)
    );

    flash_toggle_bit u_tog (
        .clk   (clk),
        .rst   (rst),
        .clear (mode == MODE_ARRAY),
        .flip  ((mode == MODE_STATUS) && rd_edge),
        .tog   (tog)
    );

    always_comb begin
        unique case (mode)
            MODE_STATUS: rd_data = busy_byte(ctx, tog);
            MODE_SETTLE: rd_data = settle_byte(array_data, tog);
            default:     rd_data = array_data;
        endcase
    end

    assign rd_drive = rd_now && !hw_rst;

    AST_ERASE_POLL_LOW: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_STATUS && ctx.kind == OP_ERASE) |-> !rd_data[POLL_BIT]);     // R3
    AST_POLL_STEADY: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_STATUS && $past(mode) == MODE_STATUS)
        |-> rd_data[POLL_BIT] == $past(rd_data[POLL_BIT]));                       // R10
    AST_TOGGLE_FLIP: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_STATUS && rd_edge) ##1 (mode == MODE_STATUS)
        |-> rd_data[TOGGLE_BIT] != $past(rd_data[TOGGLE_BIT]));                   // R4
    AST_TOGGLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_STATUS && !rd_edge) ##1 (mode == MODE_STATUS)
        |-> $stable(rd_data[TOGGLE_BIT]));                                        // R5
    AST_SETTLE_POLL_TRUE: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_SETTLE) |-> rd_data[POLL_BIT] == array_data[POLL_BIT]
                                  && rd_data[TOGGLE_BIT-1:0] == '0);              // R6
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        hw_rst |-> (!rd_drive && rd_data == array_data));                         // R8

endmodule

// File: tb/tb_flash_status_flags.sv
module tb_flash_status_flags;

    localparam int CLK_PERIOD = 10;
    localparam int TAIL       = 8;

    logic       clk = 1'b0;
    logic       rst, hw_rst, ce_n, oe_n, op_busy, op_erase, wr_poll_bit;
    logic [7:0] array_data, rd_data;
    logic       rd_drive;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_status_flags #(.TAIL_CYC(TAIL)) dut (
        .clk(clk), .rst(rst), .hw_rst(hw_rst), .ce_n(ce_n), .oe_n(oe_n),
        .op_busy(op_busy), .op_erase(op_erase), .wr_poll_bit(wr_poll_bit),
        .array_data(array_data), .rd_data(rd_data), .rd_drive(rd_drive)
    );

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(bit ok, string req, logic [7:0] act, logic [7:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic read_byte(output logic [7:0] val);
        ce_n = 1'b0; oe_n = 1'b0;
        tick(4);
        val = rd_data;
        ce_n = 1'b1; oe_n = 1'b1;
        tick(4);
    endtask

    task automatic t_reset();
        rst = 1'b1; hw_rst = 1'b0; ce_n = 1'b1; oe_n = 1'b1;
        op_busy = 1'b0; op_erase = 1'b0; wr_poll_bit = 1'b0;
        array_data = 8'h3C;
        tick(3);
        rst = 1'b0;
        tick(1);
        check(rd_drive == 1'b0, "R1", {7'd0, rd_drive}, 8'h00);
        check(rd_data == 8'h3C, "R1", rd_data, 8'h3C);
    endtask

    task automatic t_strobe();
        ce_n = 1'b0;
        tick(4);
        check(rd_drive == 1'b0, "R9 one strobe", {7'd0, rd_drive}, 8'h00);
        oe_n = 1'b0;
        tick(1);
        check(rd_drive == 1'b0, "R9 after one edge", {7'd0, rd_drive}, 8'h00);
        tick(1);
        check(rd_drive == 1'b1, "R9 after two edges", {7'd0, rd_drive}, 8'h01);
        ce_n = 1'b1; oe_n = 1'b1;
        tick(4);
    endtask

    task automatic t_program();
        logic [7:0] v;
        op_erase = 1'b0; wr_poll_bit = 1'b1;
        tick(1);
        op_busy = 1'b1;
        tick(1);
        wr_poll_bit = 1'b0;                      // R10: change while busy
        read_byte(v);
        check(v == 8'h40, "R2 R4 R1 first read", v, 8'h40);
        tick(5);
        check(rd_data[6] == 1'b1, "R5 hold", rd_data, 8'h40);
        check(rd_data[7] == 1'b0, "R10 captured bit", rd_data, 8'h40);
        read_byte(v);
        check(v == 8'h00, "R4 second read", v, 8'h00);
        read_byte(v);
        check(v == 8'h40, "R4 third read", v, 8'h40);
        array_data = 8'hC3;
        op_busy = 1'b0;
        tick(TAIL - 1);
        check(rd_data == 8'hC0, "R6 window end", rd_data, 8'hC0);
        tick(1);
        check(rd_data == 8'hC3, "R7 after window", rd_data, 8'hC3);
    endtask

    task automatic t_erase();
        logic [7:0] v;
        op_erase = 1'b1; wr_poll_bit = 1'b0;
        tick(1);
        op_busy = 1'b1;
        tick(1);
        read_byte(v);
        check(v == 8'h40, "R3 R7 first read", v, 8'h40);
        read_byte(v);
        check(v == 8'h00, "R3 R4 second read", v, 8'h00);
        array_data = 8'hFF;
        op_busy = 1'b0;
        tick(1);
        check(rd_data == 8'h80, "R6 erase window", rd_data, 8'h80);
        tick(TAIL);
        check(rd_data == 8'hFF, "R7 erase done", rd_data, 8'hFF);
    endtask

    task automatic t_hw_reset();
        logic [7:0] v;
        op_erase = 1'b0; wr_poll_bit = 1'b0; array_data = 8'h24;
        tick(1);
        op_busy = 1'b1;
        tick(1);
        ce_n = 1'b0; oe_n = 1'b0;
        tick(4);
        v = rd_data;
        check(v == 8'hC0 && rd_drive, "R2 zero bit", v, 8'hC0);
        hw_rst = 1'b1;
        #1;
        check(rd_drive == 1'b0, "R8 drive off", {7'd0, rd_drive}, 8'h00);
        check(rd_data == 8'h24, "R8 array now", rd_data, 8'h24);
        tick(2);
        hw_rst = 1'b0;
        tick(1);
        check(rd_data == 8'h24, "R8 still suppressed", rd_data, 8'h24);
        check(rd_drive == 1'b1, "R8 drive resumes", {7'd0, rd_drive}, 8'h01);
        op_busy = 1'b0;
        tick(1);
        check(rd_data == 8'h24, "R8 no window", rd_data, 8'h24);
        ce_n = 1'b1; oe_n = 1'b1;
        tick(4);
    endtask

    initial begin
        t_reset();
        t_strobe();
        t_program();
        t_erase();
        t_hw_reset();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual 00 expected 01");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule